// File: doc/BRIEF.md
# Bus Mastership Request Controller

This block asks a shared, daisy-chained grant bus for mastership on behalf of one device. It watches two device-side qualifiers: a request level and an enable level. When both are high it pulls the bus request line low. When the grant arrives from upstream it acknowledges the grant and waits until the bus is free. Then it takes the bus and tells the device it is master. Whenever the block has no request pending, it passes the incoming grant on to the next device in the chain.

There are two ways to give the bus back. The first is a clear pulse from the device. This moves the block into a lockout state, and the lockout stays until a qualifier is dropped and raised again, so one interrupt cannot be served twice. The second is to drop either qualifier, which returns the block straight to idle. That path suits plain data-transfer use. All bus-side inputs pass through a synchronizer before the state machine sees them. Every output comes from a register.

Top module: `busreq_ctrl`

## Requirements
- R1: During and after a synchronous reset, all active-low outputs are high, and `bg_out` and `intr_done` are low.
- R2: In idle, `br_n` goes low on the clock after `dev_req` and `dev_en` are both sampled high. With only one of the two high, `br_n` stays high.
- R3: `bg_out` copies `bg_in` three clocks later (two synchronizer stages plus the output register). The exception is while the block is requesting, when `bg_out` is low. It is forwarded in idle, in mastership and in lockout.
- R4: A rising edge of the synchronized grant while requesting makes `sack_n` go low and `br_n` go high on the same clock. `br_n` and `sack_n` are never low together.
- R5: After acknowledging, the block takes mastership only once both `bbsy_in_n` and `ssyn_in_n` are seen high through the synchronizer. Mastership drives `master_n`, `bbsy_n` and `bus_intr_n` low.
- R6: `sack_n` stays low through the first clock of mastership and is high from the second clock.
- R7: `start_intr_n` is low for exactly one clock, the first clock of mastership.
- R8: If either qualifier drops while requesting, before mastership, the block returns to idle: `br_n` and `sack_n` go high on the next clock.
- R9: `dev_clear` high while master releases the bus and pulses `intr_done` high for one clock. The block then keeps `br_n` high for as long as both qualifiers stay high.
- R10: From lockout, dropping a qualifier for at least one clock and raising it again makes `br_n` go low once more.
- R11: Dropping a qualifier while master releases the bus with no `intr_done` pulse, and the block returns to idle.
- R12: `dev_clear` has no effect outside mastership. A request in progress stays asserted.
- R13: `bus_vec_n` is the inverse of `vec_bit` while master and is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_req | input | 1 | Device request qualifier, active high |
| dev_en | input | 1 | Device request enable, active high |
| dev_clear | input | 1 | Release-with-lockout pulse, active high |
| vec_bit | input | 1 | Vector bit value to place on the bus while master |
| bg_in | input | 1 | Grant from upstream, active high |
| bbsy_in_n | input | 1 | Bus busy as seen on the bus, active low |
| ssyn_in_n | input | 1 | Slave sync as seen on the bus, active low |
| br_n | output | 1 | Bus request, active low |
| bg_out | output | 1 | Grant passed downstream, active high |
| sack_n | output | 1 | Selection acknowledge, active low |
| bbsy_n | output | 1 | Bus busy driven by this block, active low |
| bus_intr_n | output | 1 | Bus interrupt line, active low |
| bus_vec_n | output | 1 | Vector bit driven on the bus, active low |
| master_n | output | 1 | Device-side mastership indication, active low |
| start_intr_n | output | 1 | One-clock start strobe, active low |
| intr_done | output | 1 | One-clock done pulse after a clear release, active high |

## Verification
Every cycle, the assertions check four rules. No grant is forwarded while a request is raised. Request and acknowledge are never asserted together. The start and done strobes last a single clock, and mastership begins only after an acknowledge and a free bus. Other behaviour needs stimulus sequences that only the bench's scenarios provide. These include holding the lockout while the qualifiers stay high, re-arming after a drop-and-raise, ignoring a clear outside mastership, and the exact three-clock grant latency. The bench's reference model follows all outputs clock by clock through those sequences.

// File: rtl/busreq_pkg.sv
package busreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_REQ    = 2'b01,
    ST_MASTER = 2'b11,
    ST_LOCK   = 2'b10
  } busreq_state_t;
endpackage

// File: rtl/busreq_sync.sv
module busreq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/busreq_fsm.sv
module busreq_fsm
  import busreq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          qual,
  input  logic          clear,
  input  logic          bg_sync,
  input  logic          bus_busy,
  output busreq_state_t state_q,
  output busreq_state_t state_d,
  output logic          acked_d
);
  logic acked_q;
  logic bg_prev;
  logic bg_rise;

  assign bg_rise = bg_sync & ~bg_prev;

  always_comb begin
    state_d = state_q;
    acked_d = acked_q;
    unique case (state_q)
      ST_IDLE: if (qual) state_d = ST_REQ;
      ST_REQ: begin
        if (!qual) begin
          state_d = ST_IDLE;
          acked_d = 1'b0;
        end else if (!acked_q && bg_rise) begin
          acked_d = 1'b1;
        end else if (acked_q && !bus_busy) begin
          state_d = ST_MASTER;
          acked_d = 1'b0;
        end
      end
      ST_MASTER: begin
        if (clear) state_d = ST_LOCK;
        else if (!qual) state_d = ST_IDLE;
      end
      ST_LOCK: if (!qual) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      acked_q <= 1'b0;
      bg_prev <= 1'b0;
    end else begin
      state_q <= state_d;
      acked_q <= acked_d;
      bg_prev <= bg_sync;
    end
  end
endmodule

// File: rtl/busreq_outreg.sv
module busreq_outreg
  import busreq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  busreq_state_t state_q,
  input  busreq_state_t state_d,
  input  logic          acked_d,
  input  logic          bg_sync,
  input  logic          vec_bit,
  output logic          br_n,
  output logic          bg_out,
  output logic          sack_n,
  output logic          bbsy_n,
  output logic          bus_intr_n,
  output logic          bus_vec_n,
  output logic          master_n,
  output logic          start_intr_n,
  output logic          intr_done
);
  logic take;
  logic to_master;

  assign take      = (state_q == ST_REQ) && (state_d == ST_MASTER);
  assign to_master = (state_d == ST_MASTER);

  always_ff @(posedge clk) begin
    if (rst) begin
      br_n         <= 1'b1;
      bg_out       <= 1'b0;
      sack_n       <= 1'b1;
      bbsy_n       <= 1'b1;
      bus_intr_n   <= 1'b1;
      bus_vec_n    <= 1'b1;
      master_n     <= 1'b1;
      start_intr_n <= 1'b1;
      intr_done    <= 1'b0;
    end else begin
      br_n         <= ~((state_d == ST_REQ) && !acked_d);
      bg_out       <= bg_sync && (state_d != ST_REQ);
      sack_n       <= ~(((state_d == ST_REQ) && acked_d) || take);
      bbsy_n       <= ~to_master;
      bus_intr_n   <= ~to_master;
      bus_vec_n    <= ~(to_master && vec_bit);
      master_n     <= ~to_master;
      start_intr_n <= ~take;
      intr_done    <= (state_q == ST_MASTER) && (state_d == ST_LOCK);
    end
  end
endmodule

// File: rtl/busreq_ctrl.sv
module busreq_ctrl
  import busreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_req,
  input  logic dev_en,
  input  logic dev_clear,
  input  logic vec_bit,
  input  logic bg_in,
  input  logic bbsy_in_n,
  input  logic ssyn_in_n,
  output logic br_n,
  output logic bg_out,
  output logic sack_n,
  output logic bbsy_n,
  output logic bus_intr_n,
  output logic bus_vec_n,
  output logic master_n,
  output logic start_intr_n,
  output logic intr_done
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] raw_bus;
  logic [SYNC_W-1:0] sync_bus;
  logic              bg_sync;
  logic              bus_busy;
  busreq_state_t     state_q;
  busreq_state_t     state_d;
  logic              acked_d;

  assign raw_bus  = {~ssyn_in_n, ~bbsy_in_n, bg_in};
  assign bg_sync  = sync_bus[0];
  assign bus_busy = sync_bus[1] | sync_bus[2];

  busreq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  busreq_fsm u_fsm (
    .clk(clk), .rst(rst), .qual(dev_req & dev_en), .clear(dev_clear),
    .bg_sync(bg_sync), .bus_busy(bus_busy),
    .state_q(state_q), .state_d(state_d), .acked_d(acked_d)
  );

  busreq_outreg u_out (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d),
    .acked_d(acked_d), .bg_sync(bg_sync), .vec_bit(vec_bit),
    .br_n(br_n), .bg_out(bg_out), .sack_n(sack_n), .bbsy_n(bbsy_n),
    .bus_intr_n(bus_intr_n), .bus_vec_n(bus_vec_n), .master_n(master_n),
    .start_intr_n(start_intr_n), .intr_done(intr_done)
  );
endmodule

// File: rtl/busreq_ctrl_chk.sv
module busreq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic bus_busy,
  input logic br_n,
  input logic bg_out,
  input logic sack_n,
  input logic bus_vec_n,
  input logic master_n,
  input logic start_intr_n,
  input logic intr_done
);
  // R3
  no_grant_pass_while_req_chk: assert property (@(posedge clk) disable iff (rst)
    !br_n |-> !bg_out);
  // R4
  req_ack_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!br_n && !sack_n));
  // R5
  take_only_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(master_n) |-> !$past(bus_busy));
  // R6
  ack_held_at_take_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(master_n) |-> !sack_n);
  // R6
  ack_dropped_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(master_n) |=> sack_n);
  // R7
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !start_intr_n |=> start_intr_n);
  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    intr_done |=> !intr_done);
  // R9
  done_means_released_chk: assert property (@(posedge clk) disable iff (rst)
    intr_done |-> (master_n && br_n));
  // R13
  vec_only_as_master_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_vec_n |-> !master_n);
endmodule

bind busreq_ctrl busreq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_busy(bus_busy), .br_n(br_n), .bg_out(bg_out),
  .sack_n(sack_n), .bus_vec_n(bus_vec_n), .master_n(master_n),
  .start_intr_n(start_intr_n), .intr_done(intr_done)
);

// File: tb/tb_busreq_ctrl.sv
module tb_busreq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_req = 0, dev_en = 0, dev_clear = 0, vec_bit = 0;
  logic bg_in = 0, bbsy_in_n = 1, ssyn_in_n = 1;
  logic br_n, bg_out, sack_n, bbsy_n, bus_intr_n, bus_vec_n, master_n;
  logic start_intr_n, intr_done;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busreq_ctrl dut (.*);

  // reference model: 0 idle, 1 requesting, 2 master, 3 lockout
  int m_st = 0;
  bit m_ack = 0, m_bgq = 0, m_valid = 0;
  bit p_bg[2], p_bb[2], p_ss[2];
  bit e_br = 1, e_bg = 0, e_sack = 1, e_mst = 1, e_vec = 1, e_start = 1, e_done = 0;

  always @(posedge clk) begin
    m_valid = 1;
    if (rst) begin
      m_st = 0; m_ack = 0; m_bgq = 0;
      for (int i = 0; i < 2; i++) begin p_bg[i] = 0; p_bb[i] = 0; p_ss[i] = 0; end
      e_br = 1; e_bg = 0; e_sack = 1; e_mst = 1; e_vec = 1; e_start = 1; e_done = 0;
    end else begin
      bit qual, rise, busy, nack;
      int nst;
      qual = dev_req && dev_en;
      rise = p_bg[1] && !m_bgq;
      busy = p_bb[1] || p_ss[1];
      nst = m_st; nack = m_ack;
      if (m_st == 0) begin
        if (qual) nst = 1;
      end else if (m_st == 1) begin
        if (!qual) begin nst = 0; nack = 0; end
        else if (!m_ack && rise) nack = 1;
        else if (m_ack && !busy) begin nst = 2; nack = 0; end
      end else if (m_st == 2) begin
        if (dev_clear) nst = 3; else if (!qual) nst = 0;
      end else begin
        if (!qual) nst = 0;
      end
      e_br    = !(nst == 1 && !nack);
      e_bg    = p_bg[1] && nst != 1;
      e_sack  = !((nst == 1 && nack) || (m_st == 1 && nst == 2));
      e_mst   = !(nst == 2);
      e_vec   = !(nst == 2 && vec_bit);
      e_start = !(m_st == 1 && nst == 2);
      e_done  = (m_st == 2 && nst == 3);
      m_bgq = p_bg[1];
      p_bg[1] = p_bg[0]; p_bg[0] = bg_in;
      p_bb[1] = p_bb[0]; p_bb[0] = !bbsy_in_n;
      p_ss[1] = p_ss[0]; p_ss[0] = !ssyn_in_n;
      m_st = nst; m_ack = nack;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (m_valid && !done) begin
      chk("R2 model br_n", br_n, e_br);
      chk("R3 model bg_out", bg_out, e_bg);
      chk("R4 model sack_n", sack_n, e_sack);
      chk("R5 model master_n", master_n, e_mst);
      chk("R5 model bbsy_n", bbsy_n, e_mst);
      chk("R5 model bus_intr_n", bus_intr_n, e_mst);
      chk("R13 model bus_vec_n", bus_vec_n, e_vec);
      chk("R7 model start_intr_n", start_intr_n, e_start);
      chk("R9 model intr_done", intr_done, e_done);
    end
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    // R1 reset values
    chk("R1 br_n", br_n, 1); chk("R1 master_n", master_n, 1);
    chk("R1 bg_out", bg_out, 0); chk("R1 intr_done", intr_done, 0);
    rst = 0;
    // R2 one qualifier alone raises nothing
    dev_req = 1; step(4);
    chk("R2 single qualifier", br_n, 1);
    dev_en = 1; vec_bit = 1; step(1);
    chk("R2 request raised", br_n, 0);
    // R4/R5 grant while bus busy
    bbsy_in_n = 0; bg_in = 1; step(3);
    chk("R4 ack sack_n", sack_n, 0); chk("R4 br_n dropped", br_n, 1);
    chk("R3 no pass while requesting", bg_out, 0);
    step(4);
    chk("R5 wait for free bus", master_n, 1);
    bbsy_in_n = 1; step(2);
    chk("R5 still waiting on sync", master_n, 1);
    step(1);
    chk("R5 master taken", master_n, 0); chk("R5 bbsy_n driven", bbsy_n, 0);
    chk("R7 start strobe", start_intr_n, 0); chk("R6 sack held", sack_n, 0);
    step(1);
    chk("R7 start ends", start_intr_n, 1); chk("R6 sack dropped", sack_n, 1);
    chk("R13 vector driven", bus_vec_n, 0);
    bg_in = 0;
    // R9 clear release with lockout
    dev_clear = 1; step(1); dev_clear = 0;
    chk("R9 done pulse", intr_done, 1); chk("R9 released", master_n, 1);
    step(1);
    chk("R9 done one clock", intr_done, 0);
    step(5);
    chk("R9 lockout holds", br_n, 1);
    bg_in = 1; step(3);
    chk("R3 pass in lockout", bg_out, 1);
    bg_in = 0; step(3);
    // R10 re-arm
    dev_en = 0; step(1); dev_en = 1; step(1);
    chk("R10 re-request", br_n, 0);
    // R12 clear outside mastership
    dev_clear = 1; step(2); dev_clear = 0;
    chk("R12 clear ignored", br_n, 0);
    // R8 drop before grant
    dev_req = 0; step(1);
    chk("R8 back to idle", br_n, 1);
    bg_in = 1; step(3);
    chk("R3 pass in idle", bg_out, 1);
    bg_in = 0; step(3);
    // R11 drop qualifier while master
    dev_req = 1; vec_bit = 0; step(1);
    bg_in = 1; step(6);
    chk("R11 master before drop", master_n, 0);
    chk("R13 vector bit low", bus_vec_n, 1);
    dev_en = 0; step(1);
    chk("R11 released", master_n, 1); chk("R11 no done", intr_done, 0);
    bg_in = 0; step(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule